// File: doc/BRIEF.md
# Signed-Digit Modular Adder

This block adds two residues modulo a fixed modulus `M` without any carry chain. Each operand and the result is a word of `P` radix-2 signed digits, each digit worth -1, 0 or +1. Every digit position settles from its own two input digits, the digit pair one position below, and a transfer from that lower position. The delay through the block is therefore a fixed number of digit-logic levels for any word length. The block is purely combinational and holds no lookup tables. The result stays in redundant signed-digit form. Its integer value is congruent to the operand sum modulo `M` but is not necessarily the least residue.

The reduction is never done by comparing and subtracting. The transfer leaving the top digit carries weight 2^P, and the block folds it back into the word. The modulus parameter selects the folding structure at elaboration. For M = 2^P the top transfer is dropped. For M = 2^P - 1 it re-enters digit 0 unchanged. For M = 2^P + 1 it re-enters digit 0 negated. These three cases each use one adder row.

Any other supported modulus uses two cascaded rows. The second row adds a signed multiple of 2^P - M, and that multiple covers both the first row's top transfer and the second row's own top transfer. The second row's top transfer depends only on its two uppermost digit pairs, so it can be predicted ahead of time.

Top module: `sdmod_adder`

## Requirements
- R1: Digit i of every word occupies bits [2i+1:2i], with bit 2i+1 as the sign. The code 00 is 0, 01 is +1 and 11 is -1. The output never carries the code 10.
- R2: For any legal operands, the integer value of `sum_o` minus the sum of the integer values of `a_i` and `b_i` is a multiple of `M`.
- R3: With M = 2^P, one row is used and the transfer out of the top digit is discarded; R2 holds.
- R4: With M = 2^P - 1, one row is used and the top transfer enters digit 0 unchanged; R2 holds.
- R5: With M = 2^P + 1, one row is used and the top transfer enters digit 0 negated; R2 holds.
- R6: With 2 <= |2^P - M| <= 2^(P-3) - 1 (P >= 5), two rows are used. The second adds (first top transfer + second top transfer) times 2^P - M, and R2 holds for both signs of 2^P - M.
- R7: Two all-zero operand words give an all-zero result word.
- R8: Operands with every digit at +1, every digit at -1, or one of each, still give a result that meets R2, even though transfers then leave several positions in the same evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 2*P | First operand, P signed digits (R1 coding) |
| b_i | input | 2*P | Second operand, P signed digits (R1 coding) |
| sum_o | output | 2*P | Result, P signed digits congruent to a_i + b_i modulo M |

## Verification
Two functions can act at once: a transfer folded back from the top digit, and a transfer generated inside the word that lands on the same low digit. In the two-row structure there is a second overlap, where the first row's and the second row's top transfers both fire together and the correction becomes twice 2^P - M. Saturated operands provoke both overlaps: all +1 digits, all -1 digits, and mixed-sign patterns from a vector table, followed by several hundred random digit words. Each result is judged by reducing the decoded output and the decoded operand sum modulo M and requiring the two residues to match. One instance of every modulus class is used, including both signs of 2^P - M.

// File: rtl/sdmod_pkg.sv
package sdmod_pkg;

    // Two-bit digit code: bit 1 is the sign, bit 0 the magnitude.
    typedef logic [1:0] sdig_t;

    localparam sdig_t SD_ZERO = 2'b00;
    localparam sdig_t SD_POS  = 2'b01;
    localparam sdig_t SD_NEG  = 2'b11;

    // How the transfer leaving the top digit is folded back.
    typedef enum logic [1:0] {
        FOLD_DROP,
        FOLD_SAME,
        FOLD_NEGATE,
        FOLD_TWO_ROW
    } fold_e;

    // Per-position split of the pair sum into outgoing transfer and kept digit.
    typedef struct packed {
        logic signed [1:0] xfer;
        logic signed [1:0] keep;
    } split_t;

    function automatic logic signed [2:0] dig_val(input sdig_t d);
        case (d)
            SD_POS:  return 3'sb001;
            SD_NEG:  return 3'sb111;
            default: return 3'sb000;
        endcase
    endfunction

    function automatic sdig_t dig_enc(input logic signed [2:0] v);
        case (v)
            3'sb001: return SD_POS;
            3'sb111: return SD_NEG;
            default: return SD_ZERO;
        endcase
    endfunction

    // True when neither digit is negative: the transfer leaving that
    // position can then only be 0 or +1.
    function automatic logic nonneg_pair(input sdig_t x, input sdig_t y);
        return !x[1] && !y[1];
    endfunction

    // Choose transfer and kept digit so that the incoming transfer,
    // whose sign is bounded by lo_nonneg, cannot overflow the digit set.
    function automatic split_t split_sum(input logic signed [2:0] s,
                                         input logic lo_nonneg);
        split_t r;
        r.xfer = 2'sb00;
        r.keep = 2'sb00;
        case (s)
            3'sb010: r.xfer = 2'sb01;
            3'sb110: r.xfer = 2'sb11;
            3'sb001: begin
                if (lo_nonneg) begin
                    r.xfer = 2'sb01;
                    r.keep = 2'sb11;
                end else begin
                    r.keep = 2'sb01;
                end
            end
            3'sb111: begin
                if (lo_nonneg) begin
                    r.keep = 2'sb11;
                end else begin
                    r.xfer = 2'sb11;
                    r.keep = 2'sb01;
                end
            end
            default: ;
        endcase
        return r;
    endfunction

    // Final digit: kept digit plus incoming transfer.
    function automatic sdig_t add_digit(input logic signed [1:0] keep,
                                        input logic signed [1:0] tin);
        logic signed [2:0] t;
        t = {keep[1], keep} + {tin[1], tin};
        return dig_enc(t);
    endfunction

    // Transfer leaving a position, from its pair and the pair below it.
    function automatic logic signed [1:0] pair_xfer(input sdig_t xt, input sdig_t yt,
                                                    input sdig_t xn, input sdig_t yn);
        split_t sp;
        sp = split_sum(dig_val(xt) + dig_val(yt), nonneg_pair(xn, yn));
        return sp.xfer;
    endfunction

    function automatic fold_e pick_fold(input int p, input int m);
        if (m == (1 << p))          return FOLD_DROP;
        else if (m == (1 << p) - 1) return FOLD_SAME;
        else if (m == (1 << p) + 1) return FOLD_NEGATE;
        else                        return FOLD_TWO_ROW;
    endfunction

endpackage

// File: rtl/sdmod_row.sv
module sdmod_row
    import sdmod_pkg::*;
#(
    parameter int P = 6
) (
    input  logic [2*P-1:0]    x_i,
    input  logic [2*P-1:0]    y_i,
    input  logic signed [1:0] cin_i,
    input  logic              lo_nonneg_i,
    output logic [2*P-1:0]    z_o,
    output logic signed [1:0] cout_o
);

    logic [P-1:0]   nn;
    logic [2*P-1:0] xfer_v;

    for (genvar i = 0; i < P; i++) begin : g_pos
        sdig_t             xd;
        sdig_t             yd;
        logic              below_nonneg;
        logic signed [1:0] tin;
        split_t            sp;

        assign xd    = x_i[2*i +: 2];
        assign yd    = y_i[2*i +: 2];
        assign nn[i] = nonneg_pair(xd, yd);

        if (i == 0) begin : g_low
            assign below_nonneg = lo_nonneg_i;
            assign tin          = cin_i;
        end else begin : g_mid
            assign below_nonneg = nn[i-1];
            assign tin          = $signed(xfer_v[2*(i-1) +: 2]);
        end

        assign sp                 = split_sum(dig_val(xd) + dig_val(yd), below_nonneg);
        assign xfer_v[2*i +: 2]   = sp.xfer;
        assign z_o[2*i +: 2]      = add_digit(sp.keep, tin);
    end

    assign cout_o = $signed(xfer_v[2*P-1 -: 2]);

endmodule

// File: rtl/sdmod_corr.sv
module sdmod_corr
    import sdmod_pkg::*;
#(
    parameter int P    = 6,
    parameter int DMAG = 4,
    parameter bit DNEG = 1'b0
) (
    input  logic signed [2:0] k_i,
    output logic [2*P-1:0]    k_word_o
);

    localparam logic [P-1:0] ONCE  = DMAG[P-1:0];
    localparam logic [P-1:0] TWICE = {ONCE[P-2:0], 1'b0};

    logic [P-1:0] sel;
    logic         neg;

    always_comb begin
        case (k_i)
            3'sb001, 3'sb111: sel = ONCE;
            3'sb010, 3'sb110: sel = TWICE;
            default:          sel = '0;
        endcase
    end

    assign neg = k_i[2] ^ DNEG;

    for (genvar i = 0; i < P; i++) begin : g_dig
        assign k_word_o[2*i +: 2] = sel[i] ? (neg ? SD_NEG : SD_POS) : SD_ZERO;
    end

endmodule

// File: rtl/sdmod_adder.sv
module sdmod_adder
    import sdmod_pkg::*;
#(
    parameter int P = 6,
    parameter int M = 60
) (
    input  logic [2*P-1:0] a_i,
    input  logic [2*P-1:0] b_i,
    output logic [2*P-1:0] sum_o
);

    localparam fold_e FOLD = pick_fold(P, M);
    localparam int    DIST = (1 << P) - M;
    localparam int    DMAG = (DIST < 0) ? -DIST : DIST;
    localparam bit    DNEG = (DIST < 0);

    // Predicted top transfer and the one the last row actually emits.
    logic signed [1:0] fold_pred;
    logic signed [1:0] fold_seen;

    if (FOLD == FOLD_TWO_ROW) begin : g_two
        logic [2*P-1:0]    z1;
        logic [2*P-1:0]    kw;
        logic signed [1:0] c1;
        logic signed [2:0] k_sum;

        sdmod_row #(.P(P)) u_row1 (
            .x_i        (a_i),
            .y_i        (b_i),
            .cin_i      (2'sb00),
            .lo_nonneg_i(1'b1),
            .z_o        (z1),
            .cout_o     (c1)
        );

        // Correction digits stay below the top two positions, so the second
        // row's top transfer depends on z1 alone.
        assign fold_pred = pair_xfer(z1[2*P-1 -: 2], SD_ZERO, z1[2*P-3 -: 2], SD_ZERO);
        assign k_sum     = {c1[1], c1} + {fold_pred[1], fold_pred};

        sdmod_corr #(.P(P), .DMAG(DMAG), .DNEG(DNEG)) u_corr (
            .k_i     (k_sum),
            .k_word_o(kw)
        );

        sdmod_row #(.P(P)) u_row2 (
            .x_i        (z1),
            .y_i        (kw),
            .cin_i      (2'sb00),
            .lo_nonneg_i(1'b1),
            .z_o        (sum_o),
            .cout_o     (fold_seen)
        );
    end else begin : g_one
        logic signed [1:0] wrap_in;
        logic              wrap_nonneg;
        logic              top_nonneg;

        assign fold_pred  = pair_xfer(a_i[2*P-1 -: 2], b_i[2*P-1 -: 2],
                                      a_i[2*P-3 -: 2], b_i[2*P-3 -: 2]);
        assign top_nonneg = nonneg_pair(a_i[2*P-1 -: 2], b_i[2*P-1 -: 2]);

        if (FOLD == FOLD_SAME) begin : g_same
            assign wrap_in     = fold_pred;
            assign wrap_nonneg = top_nonneg;
        end else if (FOLD == FOLD_NEGATE) begin : g_neg
            assign wrap_in     = -fold_pred;
            assign wrap_nonneg = !top_nonneg;
        end else begin : g_drop
            assign wrap_in     = 2'sb00;
            assign wrap_nonneg = 1'b1;
        end

        sdmod_row #(.P(P)) u_row (
            .x_i        (a_i),
            .y_i        (b_i),
            .cin_i      (wrap_in),
            .lo_nonneg_i(wrap_nonneg),
            .z_o        (sum_o),
            .cout_o     (fold_seen)
        );
    end

endmodule

// File: rtl/sdmod_adder_chk.sv
module sdmod_adder_chk
    import sdmod_pkg::*;
#(
    parameter int P = 6,
    parameter int M = 60
) (
    input logic [2*P-1:0]    a_i,
    input logic [2*P-1:0]    b_i,
    input logic [2*P-1:0]    sum_o,
    input logic signed [1:0] fold_pred,
    input logic signed [1:0] fold_seen
);

    function automatic int word_int(input logic [2*P-1:0] w);
        int acc;
        acc = 0;
        for (int i = P - 1; i >= 0; i--) begin
            acc = acc * 2 + int'(dig_val(w[2*i +: 2]));
        end
        return acc;
    endfunction

    logic has_bad_code;
    int   diff;

    always_comb begin
        has_bad_code = 1'b0;
        for (int i = 0; i < P; i++) begin
            if (sum_o[2*i +: 2] == 2'b10) has_bad_code = 1'b1;
        end
        diff = word_int(a_i) + word_int(b_i) - word_int(sum_o);

        // R1
        legal_code_chk: assert (!has_bad_code)
            else $error("output holds digit code 10: %h", sum_o);
        // R2
        congruent_chk: assert ((diff % M) == 0)
            else $error("result not congruent, difference %0d", diff);
        // R2
        fold_match_chk: assert (fold_pred == fold_seen)
            else $error("predicted top transfer %0d, emitted %0d", fold_pred, fold_seen);
        // R7
        zero_word_chk: assert (!((a_i == '0) && (b_i == '0)) || (sum_o == '0))
            else $error("zero operands gave %h", sum_o);
    end

endmodule

bind sdmod_adder sdmod_adder_chk #(.P(P), .M(M)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .sum_o    (sum_o),
    .fold_pred(fold_pred),
    .fold_seen(fold_seen)
);

// File: tb/tb_sdmod_adder.sv
module tb_sdmod_adder;

    localparam int P = 6;
    localparam int W = 2 * P;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_w = '0;
    logic [W-1:0] b_w = '0;
    logic [W-1:0] s_gen;
    logic [W-1:0] s_pow;
    logic [W-1:0] s_same;
    logic [W-1:0] s_neg;
    logic [W-1:0] s_gen2;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    // 2^P - M = +4, two rows
    sdmod_adder #(.P(P), .M(60)) dut     (.a_i(a_w), .b_i(b_w), .sum_o(s_gen));
    sdmod_adder #(.P(P), .M(64)) u_pow   (.a_i(a_w), .b_i(b_w), .sum_o(s_pow));
    sdmod_adder #(.P(P), .M(63)) u_same  (.a_i(a_w), .b_i(b_w), .sum_o(s_same));
    sdmod_adder #(.P(P), .M(65)) u_neg   (.a_i(a_w), .b_i(b_w), .sum_o(s_neg));
    // 2^P - M = -5, two rows
    sdmod_adder #(.P(P), .M(69)) u_gen2  (.a_i(a_w), .b_i(b_w), .sum_o(s_gen2));

    // Operand pairs {a, b}; nibbles use only legal digit codes.
    localparam logic [2*W-1:0] VEC [0:11] = '{
        24'h555555, 24'hFFFFFF, 24'h555FFF, 24'hFFF555,
        24'h000001, 24'h7D7D7D, 24'h400400, 24'hC00C00,
        24'h1F13C3, 24'h54C0DF, 24'h0FD71C, 24'h57F3DC
    };

    function automatic int sd_value(input logic [W-1:0] w);
        int acc = 0;
        for (int i = W / 2 - 1; i >= 0; i--) begin
            case (w[2*i +: 2])
                2'b01:   acc = acc * 2 + 1;
                2'b11:   acc = acc * 2 - 1;
                default: acc = acc * 2;
            endcase
        end
        return acc;
    endfunction

    function automatic int residue(input int v, input int m);
        int r = v % m;
        if (r < 0) r += m;
        return r;
    endfunction

    task automatic check_mod(input string tag, input logic [W-1:0] w,
                             input int m, input int truth);
        int got = residue(sd_value(w), m);
        int exp = residue(truth, m);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s mod %0d actual=%0d expected=%0d", tag, m, got, exp);
        end
    endtask

    task automatic check_code(input string tag, input logic [W-1:0] w);
        bit bad = 1'b0;
        for (int i = 0; i < P; i++) begin
            if (w[2*i +: 2] == 2'b10) bad = 1'b1;
        end
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s R1 actual=%h expected=no digit code 10", tag, w);
        end
    endtask

    task automatic check_zero(input string tag, input logic [W-1:0] w);
        checks++;
        if (w != '0) begin
            errors++;
            $display("FAIL %s R7 actual=%h expected=%h", tag, w, {W{1'b0}});
        end
    endtask

    task automatic run_pair(input logic [W-1:0] av, input logic [W-1:0] bv,
                            input string grp);
        int truth;
        @(negedge clk);
        a_w = av;
        b_w = bv;
        #1;
        truth = sd_value(av) + sd_value(bv);
        check_mod({grp, " R6 R2 two-row +4"}, s_gen,  60, truth);
        check_mod({grp, " R3 R2 drop"},        s_pow,  64, truth);
        check_mod({grp, " R4 R2 same-fold"},   s_same, 63, truth);
        check_mod({grp, " R5 R2 negate-fold"}, s_neg,  65, truth);
        check_mod({grp, " R6 R2 two-row -5"},  s_gen2, 69, truth);
        check_code({grp, " gen"},  s_gen);
        check_code({grp, " pow"},  s_pow);
        check_code({grp, " same"}, s_same);
        check_code({grp, " neg"},  s_neg);
        check_code({grp, " gen2"}, s_gen2);
    endtask

    function automatic logic [W-1:0] rand_word();
        logic [W-1:0] w;
        for (int i = 0; i < P; i++) begin
            case ($urandom % 3)
                0:       w[2*i +: 2] = 2'b00;
                1:       w[2*i +: 2] = 2'b01;
                default: w[2*i +: 2] = 2'b11;
            endcase
        end
        return w;
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // Reset state: zero operands held during bench reset (R7).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_zero("reset gen",  s_gen);
        check_zero("reset pow",  s_pow);
        check_zero("reset same", s_same);
        check_zero("reset neg",  s_neg);
        check_zero("reset gen2", s_gen2);
        rst = 1'b0;

        // Vector table.
        for (int v = 0; v < 12; v++) begin
            run_pair(VEC[v][2*W-1:W], VEC[v][W-1:0], "table");
        end

        // R8: saturated operands, folded transfers overlap internal ones.
        run_pair({P{2'b01}}, {P{2'b01}}, "R8 all+1");
        run_pair({P{2'b11}}, {P{2'b11}}, "R8 all-1");
        run_pair({P{2'b01}}, {P{2'b11}}, "R8 mixed");
        run_pair({P{2'b11}}, {P{2'b01}}, "R8 mixed rev");

        // Random digit words.
        for (int n = 0; n < 300; n++) begin
            run_pair(rand_word(), rand_word(), "random");
        end

        // R7: zero operands after activity.
        @(negedge clk);
        a_w = '0;
        b_w = '0;
        #1;
        check_zero("after gen",  s_gen);
        check_zero("after pow",  s_pow);
        check_zero("after same", s_same);
        check_zero("after neg",  s_neg);
        check_zero("after gen2", s_gen2);

        done = 1'b1;
        finish_run();
    end

endmodule